// File: doc/BRIEF.md
# Configuration Space Access Decoder

This block sits between a host-side configuration request source and a flat memory-mapped configuration window. Each request names a bus, a device/function pair and a register offset. An accepted request leaves the block as one window address, with the bus number at bit 20, the device/function number at bit 12 and the register offset in the low 12 bits. The write flag and byte enables go with it unchanged.

Some requests must not reach the link, and the block stops them. While the link is down, a request to any bus other than the root bus is turned back. On the root bus itself only device/function 0 is present, so every other device/function there is turned back as well. A turned-back read completes with all-ones data and a turned-back write is dropped. Either way, exactly one response of one kind appears one cycle after the request.

The root bus number is held in an 8-bit register that resets to 0. The link state is bit 11 of a PHY status word. A constant information word carries the window size code in bits 18:16.

Top module: `ecam_cfg_decoder`

## Requirements
- R1: An accepted request produces fwd_addr = (bus << 20) | (devfn << 12) | reg, 28 bits wide by default.
- R2: A request whose bus differs from the root bus number is rejected while bit 11 of phy_status is 0.
- R3: A request on the root bus with devfn other than 0 is rejected whatever the link state.
- R4: A root-bus request with devfn 0 is forwarded whatever the link state. An off-root request is forwarded when bit 11 of phy_status is 1.
- R5: A rejected read (rej_write = 0) returns rej_rdata of all ones. A rejected write returns rej_write = 1, rej_rdata of 0, and no forwarded request.
- R6: Every request cycle is followed, one cycle later, by exactly one of fwd_valid or rej_valid. A cycle without a request is followed by neither.
- R7: fwd_write and fwd_be equal the request's write flag and byte enables.
- R8: The root bus number resets to 0. A write through root_we takes effect for requests from the next cycle on.
- R9: window_info holds the size code BUS_BITS-1 (7 by default) in bits 18:16, and 0 in every other bit.
- R10: Bits of phy_status other than bit 11 have no effect on whether a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load the root bus number register |
| root_wdata | input | 8 | New root bus number |
| phy_status | input | 16 | PHY status word; bit 11 is link up |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request is a write |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_reg | input | 12 | Register offset |
| req_be | input | 4 | Byte enables |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | 28 | Window address |
| fwd_be | output | 4 | Forwarded byte enables |
| rej_valid | output | 1 | Rejection response valid |
| rej_write | output | 1 | Rejected request was a write |
| rej_rdata | output | 32 | Read data for a rejected request |
| window_info | output | 32 | Constant info word with the size code in bits 18:16 |

## Verification
The properties assume that the request fields and phy_status are stable and known on every cycle with req_valid high. They also assume that root_we is never asserted in the same cycle as a request, so the root number a request is judged against is unambiguous. The stimulus follows both assumptions. Root bus changes are applied on cycles of their own. Each request is driven for one cycle and followed by an idle cycle. The bench then sweeps buses, device/functions, both link states and two root numbers, with noise in the unused PHY status bits.

// File: rtl/ecam_cfg_pkg.sv
package ecam_cfg_pkg;
   localparam int unsigned SIZE_FIELD_LSB = 16;
   localparam int unsigned SIZE_FIELD_W   = 3;

   function automatic logic [SIZE_FIELD_W-1:0] size_code(input int unsigned bus_bits);
      return SIZE_FIELD_W'(bus_bits - 1);
   endfunction
endpackage

// File: rtl/ecam_root_bus_reg.sv
module ecam_root_bus_reg #(
   parameter int unsigned BUS_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [BUS_BITS-1:0] wdata,
   output logic [BUS_BITS-1:0] root_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  root_q <= '0;
      else if (we) root_q <= wdata;
   end
endmodule

// File: rtl/ecam_target_filter.sv
module ecam_target_filter #(
   parameter int unsigned BUS_BITS = 8,
   parameter int unsigned DEVFN_W  = 8,
   parameter int unsigned PHY_W    = 16,
   parameter int unsigned LINK_BIT = 11
) (
   input  logic [BUS_BITS-1:0] bus,
   input  logic [DEVFN_W-1:0]  devfn,
   input  logic [BUS_BITS-1:0] root_bus,
   input  logic [PHY_W-1:0]    phy_status,
   output logic                accept
);
   localparam logic [PHY_W-1:0] LINK_MASK = PHY_W'(1) << LINK_BIT;

   logic link_up, on_root;

   assign link_up = |(phy_status & LINK_MASK);
   assign on_root = (bus == root_bus);

   always_comb begin
      if (on_root) accept = (devfn == '0);
      else         accept = link_up;
   end
endmodule

// File: rtl/ecam_addr_pack.sv
module ecam_addr_pack #(
   parameter int unsigned BUS_BITS = 8,
   parameter int unsigned DEVFN_W  = 8,
   parameter int unsigned REG_W    = 12,
   localparam int unsigned BUS_SHIFT = DEVFN_W + REG_W,
   localparam int unsigned ADDR_W    = BUS_SHIFT + BUS_BITS
) (
   input  logic [BUS_BITS-1:0] bus,
   input  logic [DEVFN_W-1:0]  devfn,
   input  logic [REG_W-1:0]    regofs,
   output logic [ADDR_W-1:0]   addr
);
   assign addr = (ADDR_W'(bus) << BUS_SHIFT)
               | (ADDR_W'(devfn) << REG_W)
               | ADDR_W'(regofs);
endmodule

// File: rtl/ecam_cfg_decoder.sv
module ecam_cfg_decoder
   import ecam_cfg_pkg::*;
#(
   parameter int unsigned BUS_BITS = 8,
   parameter int unsigned DEVFN_W  = 8,
   parameter int unsigned REG_W    = 12,
   parameter int unsigned BE_W     = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PHY_W    = 16,
   parameter int unsigned LINK_BIT = 11,
   localparam int unsigned ADDR_W  = BUS_BITS + DEVFN_W + REG_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                root_we,
   input  logic [BUS_BITS-1:0] root_wdata,
   input  logic [PHY_W-1:0]    phy_status,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [BUS_BITS-1:0] req_bus,
   input  logic [DEVFN_W-1:0]  req_devfn,
   input  logic [REG_W-1:0]    req_reg,
   input  logic [BE_W-1:0]     req_be,
   output logic                fwd_valid,
   output logic                fwd_write,
   output logic [ADDR_W-1:0]   fwd_addr,
   output logic [BE_W-1:0]     fwd_be,
   output logic                rej_valid,
   output logic                rej_write,
   output logic [DATA_W-1:0]   rej_rdata,
   output logic [DATA_W-1:0]   window_info
);
   generate
      if (BUS_BITS < 1 || BUS_BITS > 8) begin : g_bad_bus
         $error("BUS_BITS must lie in 1..8 to fit the size code");
      end
      if (LINK_BIT >= PHY_W) begin : g_bad_link
         $error("LINK_BIT must index into phy_status");
      end
      if (DATA_W < SIZE_FIELD_LSB + SIZE_FIELD_W) begin : g_bad_data
         $error("DATA_W too narrow for the size field");
      end
   endgenerate

   logic [BUS_BITS-1:0] root_q;
   logic                accept;
   logic [ADDR_W-1:0]   addr_c;

   ecam_root_bus_reg #(.BUS_BITS(BUS_BITS)) i_root (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (root_we),
      .wdata  (root_wdata),
      .root_q (root_q)
   );

   ecam_target_filter #(
      .BUS_BITS(BUS_BITS), .DEVFN_W(DEVFN_W), .PHY_W(PHY_W), .LINK_BIT(LINK_BIT)
   ) i_filter (
      .bus        (req_bus),
      .devfn      (req_devfn),
      .root_bus   (root_q),
      .phy_status (phy_status),
      .accept     (accept)
   );

   ecam_addr_pack #(
      .BUS_BITS(BUS_BITS), .DEVFN_W(DEVFN_W), .REG_W(REG_W)
   ) i_pack (
      .bus    (req_bus),
      .devfn  (req_devfn),
      .regofs (req_reg),
      .addr   (addr_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         fwd_write <= 1'b0;
         fwd_addr  <= '0;
         fwd_be    <= '0;
         rej_valid <= 1'b0;
         rej_write <= 1'b0;
         rej_rdata <= '0;
      end else begin
         fwd_valid <= req_valid && accept;
         rej_valid <= req_valid && !accept;
         if (req_valid && accept) begin
            fwd_write <= req_write;
            fwd_addr  <= addr_c;
            fwd_be    <= req_be;
         end
         if (req_valid && !accept) begin
            rej_write <= req_write;
            rej_rdata <= req_write ? '0 : '1;
         end
      end
   end

   assign window_info = DATA_W'(size_code(BUS_BITS)) << SIZE_FIELD_LSB;
endmodule

// File: rtl/ecam_cfg_decoder_chk.sv
module ecam_cfg_decoder_chk #(
   parameter int unsigned BUS_BITS = 8,
   parameter int unsigned DEVFN_W  = 8,
   parameter int unsigned REG_W    = 12,
   parameter int unsigned BE_W     = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PHY_W    = 16,
   parameter int unsigned LINK_BIT = 11,
   localparam int unsigned ADDR_W  = BUS_BITS + DEVFN_W + REG_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic                root_we,
   input logic [BUS_BITS-1:0] root_wdata,
   input logic [BUS_BITS-1:0] root_q,
   input logic [PHY_W-1:0]    phy_status,
   input logic                req_valid,
   input logic                req_write,
   input logic [BUS_BITS-1:0] req_bus,
   input logic [DEVFN_W-1:0]  req_devfn,
   input logic [REG_W-1:0]    req_reg,
   input logic [BE_W-1:0]     req_be,
   input logic                fwd_valid,
   input logic                fwd_write,
   input logic [ADDR_W-1:0]   fwd_addr,
   input logic [BE_W-1:0]     fwd_be,
   input logic                rej_valid,
   input logic                rej_write,
   input logic [DATA_W-1:0]   rej_rdata
);
   localparam logic [PHY_W-1:0] LMASK = PHY_W'(1) << LINK_BIT;
   logic link;
   assign link = |(phy_status & LMASK);

   // R1
   addr_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> fwd_addr == {$past(req_bus), $past(req_devfn), $past(req_reg)});
   // R2
   offroot_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bus != root_q && !link) |=> rej_valid);
   // R3
   root_devfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bus == root_q && req_devfn != '0) |=> rej_valid);
   // R4
   root_fn0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bus == root_q && req_devfn == '0) |=> fwd_valid);
   // R5
   rej_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rej_valid && !rej_write) |-> (rej_rdata == '1));
   // R6
   one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> $onehot({fwd_valid, rej_valid}));
   // R6
   no_idle_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(fwd_valid || rej_valid));
   // R7
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (fwd_write == $past(req_write) && fwd_be == $past(req_be)));
   // R8
   root_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      root_we |=> root_q == $past(root_wdata));
endmodule

bind ecam_cfg_decoder ecam_cfg_decoder_chk #(
   .BUS_BITS(BUS_BITS), .DEVFN_W(DEVFN_W), .REG_W(REG_W), .BE_W(BE_W),
   .DATA_W(DATA_W), .PHY_W(PHY_W), .LINK_BIT(LINK_BIT)
) i_chk (
   .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
   .root_q(root_q), .phy_status(phy_status), .req_valid(req_valid),
   .req_write(req_write), .req_bus(req_bus), .req_devfn(req_devfn),
   .req_reg(req_reg), .req_be(req_be), .fwd_valid(fwd_valid),
   .fwd_write(fwd_write), .fwd_addr(fwd_addr), .fwd_be(fwd_be),
   .rej_valid(rej_valid), .rej_write(rej_write), .rej_rdata(rej_rdata)
);

// File: tb/test_ecam_cfg_decoder.sv
module test_ecam_cfg_decoder;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        root_we;
   logic [7:0]  root_wdata;
   logic [15:0] phy_status;
   logic        req_valid, req_write;
   logic [7:0]  req_bus, req_devfn;
   logic [11:0] req_reg;
   logic [3:0]  req_be;
   logic        fwd_valid, fwd_write, rej_valid, rej_write;
   logic [27:0] fwd_addr;
   logic [3:0]  fwd_be;
   logic [31:0] rej_rdata, window_info;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(PERIOD/2) clk = ~clk;

   ecam_cfg_decoder i_ecam_cfg_decoder (
      .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
      .phy_status(phy_status), .req_valid(req_valid), .req_write(req_write),
      .req_bus(req_bus), .req_devfn(req_devfn), .req_reg(req_reg), .req_be(req_be),
      .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_addr(fwd_addr),
      .fwd_be(fwd_be), .rej_valid(rej_valid), .rej_write(rej_write),
      .rej_rdata(rej_rdata), .window_info(window_info)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_root(input logic [7:0] v);
      @(negedge clk);
      root_we = 1'b1; root_wdata = v;
      @(negedge clk);
      root_we = 1'b0;
   endtask

   // One request, checked one cycle later, then an idle cycle checked too.
   task automatic apply(input logic [7:0] root, input logic [15:0] phy,
                        input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [11:0] rg, input logic [3:0] be, input logic wr);
      bit exp_acc;
      logic [27:0] exp_addr;
      exp_acc  = (bus == root) ? (devfn == 8'd0) : phy[11];
      exp_addr = ({20'd0, bus} << 20) + ({20'd0, devfn} << 12) + {16'd0, rg};
      @(negedge clk);
      phy_status = phy; req_valid = 1'b1; req_write = wr;
      req_bus = bus; req_devfn = devfn; req_reg = rg; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      if (exp_acc) begin
         // R1 R4 R7
         check(fwd_valid && !rej_valid, "R4", {62'd0, fwd_valid, rej_valid}, 64'h2);
         check(fwd_addr == exp_addr, "R1", 64'(fwd_addr), 64'(exp_addr));
         check(fwd_be == be && fwd_write == wr, "R7", {59'd0, fwd_write, fwd_be},
               {59'd0, wr, be});
      end else begin
         // R2 R3 R5
         check(rej_valid && !fwd_valid, (bus == root) ? "R3" : "R2",
               {62'd0, fwd_valid, rej_valid}, 64'h1);
         check(rej_write == wr && rej_rdata == (wr ? 32'h0 : 32'hFFFF_FFFF), "R5",
               {31'd0, rej_write, rej_rdata}, {31'd0, wr, (wr ? 32'h0 : 32'hFFFF_FFFF)});
      end
      @(negedge clk);
      // R6
      check(!fwd_valid && !rej_valid, "R6", {62'd0, fwd_valid, rej_valid}, 64'h0);
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] roots [2];
      logic [7:0] devs  [5];
      roots[0] = 8'd0; roots[1] = 8'd3;
      devs[0] = 8'd0; devs[1] = 8'd1; devs[2] = 8'd2; devs[3] = 8'd8; devs[4] = 8'hFF;
      rst_n = 1'b0; root_we = 1'b0; root_wdata = '0; phy_status = '0;
      req_valid = 1'b0; req_write = 1'b0; req_bus = '0; req_devfn = '0;
      req_reg = '0; req_be = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!fwd_valid && !rej_valid && fwd_addr == '0, "R6",
            {35'd0, fwd_valid, fwd_addr}, 64'h0);
      // R9
      check(window_info == 32'h0007_0000, "R9", 64'(window_info), 64'h0007_0000);
      // R8: reset root 0 -> bus 0 devfn 1 rejected, bus 0 devfn 0 forwarded
      apply(8'd0, 16'h0000, 8'd0, 8'd1, 12'h010, 4'hF, 1'b0);
      apply(8'd0, 16'h0000, 8'd0, 8'd0, 12'h010, 4'hF, 1'b0);
      // R10: all other status bits high, link bit low
      apply(8'd0, 16'hF7FF, 8'd4, 8'd0, 12'hABC, 4'h3, 1'b0);
      apply(8'd0, 16'h0800, 8'd4, 8'd0, 12'hABC, 4'h3, 1'b1);
      for (int r = 0; r < 2; r++) begin
         // R8
         set_root(roots[r]);
         for (int lk = 0; lk < 2; lk++) begin
            for (int b = 0; b < 9; b++) begin
               for (int d = 0; d < 5; d++) begin
                  logic [7:0]  bb;
                  logic [15:0] ph;
                  bb = (b == 8) ? 8'hFF : 8'(b);
                  ph = (lk != 0) ? (16'h0800 | 16'(b * 16'h0123 & 16'hF7FF))
                                 : (16'(b * 16'h0123) & 16'hF7FF);
                  apply(roots[r], ph, bb, devs[d], 12'((b * 37 + d * 5 + r) & 12'hFFF),
                        4'((b + d) & 4'hF), 1'((b + d + lk) & 1));
               end
            end
         end
      end
      // R8: root moved to 0xFF
      set_root(8'hFF);
      apply(8'hFF, 16'h0000, 8'hFF, 8'd0, 12'hFFF, 4'h1, 1'b0);
      apply(8'hFF, 16'h0000, 8'd0, 8'd0, 12'hFFF, 4'h1, 1'b0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule